// File: doc/BRIEF.md
# Hysteresis Temperature Controller

This block compares a measured temperature with a set-point and drives two enables: one for a heater and one for a cooler. A tolerance band around the set-point controls when each enable switches. The block leaves its resting state only when the reading is more than the tolerance away from the set-point. Once it is heating or cooling, it keeps going until the reading reaches the set-point itself. This gap between the start and stop thresholds keeps the enables from toggling on every small wobble of the reading.

All values are unsigned. The controller state is held in a one-hot register, and that register is also brought out at a port. The block uses no sensor conversion and no model of the thermal plant. A surrounding system, or the testbench, closes the loop by turning the enables into temperature changes.

Top module: `thermo_ctrl`

## Requirements
- R1: While `rstN` is low, the state is resting: `stateOneHot` = 3'b001 and both enables are low.
- R2: The state encoding is one-hot. Bit 0 is resting, bit 1 is heating and bit 2 is cooling. Exactly one bit is set after every clock edge.
- R3: From resting, when `curTemp + tolBand < setTemp`, the state is heating after the next clock edge.
- R4: From resting, when `curTemp > setTemp + tolBand`, the state is cooling after the next clock edge.
- R5: From resting, when `setTemp - tolBand <= curTemp <= setTemp + tolBand` (evaluated without wrap), the state stays resting.
- R6: In heating, the state stays heating while `curTemp < setTemp`. It returns to resting after the edge at which `curTemp >= setTemp`.
- R7: In cooling, the state stays cooling while `curTemp > setTemp`. It returns to resting after the edge at which `curTemp <= setTemp`.
- R8: `heaterOn` is high exactly in heating and `coolerOn` is high exactly in cooling. The two are never high together.
- R9: The threshold comparisons are made one bit wider than the temperatures, so they never wrap when the set-point is near 0 or near full scale.
- R10: Consider a plant that adds 2 degrees every 10 heating cycles and removes 3 degrees every 5 cooling cycles. Driven by this block, it settles in resting with the reading inside the tolerance band.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| curTemp | input | TEMP_W (8) | Measured temperature, unsigned |
| setTemp | input | TEMP_W (8) | Desired temperature, unsigned |
| tolBand | input | TOL_W (4) | Tolerance around the set-point, unsigned |
| heaterOn | output | 1 | Heater enable |
| coolerOn | output | 1 | Cooler enable |
| stateOneHot | output | 3 | One-hot state: bit 0 resting, bit 1 heating, bit 2 cooling |

## Verification
The bench builds the block with its default widths: 8-bit temperatures and a 4-bit tolerance. At these widths a tolerance of 15 next to a set-point of 0, 3, 250 or 255 exposes any threshold arithmetic that wraps. Every edge of the one-hot state, including equality at both band edges, can be reached with a few hundred random readings clustered near the set-point. Two closed-loop runs, one starting cold and one starting hot, show that the slow plant settles inside the band.

// File: rtl/thermo_pkg.sv
package thermo_pkg;

  localparam int STATE_W = 3;

  // One-hot state codes: bit 0 resting, bit 1 heating, bit 2 cooling
  localparam logic [STATE_W-1:0] ST_REST = 3'b001;
  localparam logic [STATE_W-1:0] ST_HEAT = 3'b010;
  localparam logic [STATE_W-1:0] ST_COOL = 3'b100;

  // Comparison strobes from the datapath to the control
  typedef struct packed {
    logic tooCold;    // reading below the lower band edge
    logic tooHot;     // reading above the upper band edge
    logic atOrAbove;  // reading has reached the set-point from below
    logic atOrBelow;  // reading has reached the set-point from above
  } cmpFlags_t;

endpackage

// File: rtl/thermo_datapath.sv
module thermo_datapath
  import thermo_pkg::*;
#(
  parameter int TEMP_W = 8,
  parameter int TOL_W  = 4
) (
  input  logic [TEMP_W-1:0] curTemp,
  input  logic [TEMP_W-1:0] setTemp,
  input  logic [TOL_W-1:0]  tolBand,
  output cmpFlags_t         flags
);

  localparam int CMP_W = TEMP_W + 1;

  logic [CMP_W-1:0] curWide;
  logic [CMP_W-1:0] setWide;
  logic [CMP_W-1:0] tolWide;
  logic [CMP_W-1:0] curPlusTol;
  logic [CMP_W-1:0] setPlusTol;

  assign curWide = {1'b0, curTemp};
  assign setWide = {1'b0, setTemp};
  assign tolWide = {{(CMP_W-TOL_W){1'b0}}, tolBand};

  // Both sums fit in CMP_W bits, so nothing is subtracted and nothing wraps
  assign curPlusTol = curWide + tolWide;
  assign setPlusTol = setWide + tolWide;

  always_comb begin
    flags.tooCold   = curPlusTol < setWide;
    flags.tooHot    = curWide > setPlusTol;
    flags.atOrAbove = curWide >= setWide;
    flags.atOrBelow = curWide <= setWide;
  end

endmodule

// File: rtl/thermo_control.sv
module thermo_control
  import thermo_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  cmpFlags_t          flags,
  output logic [STATE_W-1:0] stateQ,
  output logic               heaterOn,
  output logic               coolerOn
);

  logic [STATE_W-1:0] stateNxt;

  always_comb begin
    case (stateQ)
      ST_REST: begin
        if (flags.tooCold)     stateNxt = ST_HEAT;
        else if (flags.tooHot) stateNxt = ST_COOL;
        else                   stateNxt = ST_REST;
      end
      ST_HEAT: stateNxt = flags.atOrAbove ? ST_REST : ST_HEAT;
      ST_COOL: stateNxt = flags.atOrBelow ? ST_REST : ST_COOL;
      default: stateNxt = ST_REST;  // any illegal code falls back to resting
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateQ <= ST_REST;
    else       stateQ <= stateNxt;
  end

  assign heaterOn = (stateQ == ST_HEAT);
  assign coolerOn = (stateQ == ST_COOL);

endmodule

// File: rtl/thermo_ctrl.sv
module thermo_ctrl
  import thermo_pkg::*;
#(
  parameter int TEMP_W = 8,
  parameter int TOL_W  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [TEMP_W-1:0] curTemp,
  input  logic [TEMP_W-1:0] setTemp,
  input  logic [TOL_W-1:0]  tolBand,
  output logic              heaterOn,
  output logic              coolerOn,
  output logic [2:0]        stateOneHot
);

  cmpFlags_t cmpFlags;

  thermo_datapath #(.TEMP_W(TEMP_W), .TOL_W(TOL_W)) u_dp (
    .curTemp (curTemp),
    .setTemp (setTemp),
    .tolBand (tolBand),
    .flags   (cmpFlags)
  );

  thermo_control u_ctl (
    .clk      (clk),
    .rstN     (rstN),
    .flags    (cmpFlags),
    .stateQ   (stateOneHot),
    .heaterOn (heaterOn),
    .coolerOn (coolerOn)
  );

endmodule

// File: rtl/thermo_ctrl_chk.sv
module thermo_ctrl_chk #(
  parameter int TEMP_W = 8,
  parameter int TOL_W  = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic [TEMP_W-1:0] curTemp,
  input logic [TEMP_W-1:0] setTemp,
  input logic [TOL_W-1:0]  tolBand,
  input logic              heaterOn,
  input logic              coolerOn,
  input logic [2:0]        stateOneHot
);

  logic [TEMP_W:0] lowSum;
  logic [TEMP_W:0] highSum;
  logic            isRest;
  logic            isHeat;
  logic            isCool;

  assign lowSum  = {1'b0, curTemp} + {{(TEMP_W+1-TOL_W){1'b0}}, tolBand};
  assign highSum = {1'b0, setTemp} + {{(TEMP_W+1-TOL_W){1'b0}}, tolBand};
  assign isRest  = stateOneHot == 3'b001;
  assign isHeat  = stateOneHot == 3'b010;
  assign isCool  = stateOneHot == 3'b100;

  AST_ONE_HOT: assert property (@(posedge clk) disable iff (!rstN)
    $countones(stateOneHot) == 1);  // R2
  AST_HEAT_ENTRY: assert property (@(posedge clk) disable iff (!rstN)
    (isRest && lowSum < {1'b0, setTemp}) |=> isHeat);  // R3
  AST_COOL_ENTRY: assert property (@(posedge clk) disable iff (!rstN)
    (isRest && {1'b0, curTemp} > highSum) |=> isCool);  // R4
  AST_BAND_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (isRest && lowSum >= {1'b0, setTemp} && {1'b0, curTemp} <= highSum) |=> isRest);  // R5
  AST_HEAT_EXIT: assert property (@(posedge clk) disable iff (!rstN)
    (isHeat && curTemp >= setTemp) |=> isRest);  // R6
  AST_COOL_EXIT: assert property (@(posedge clk) disable iff (!rstN)
    (isCool && curTemp <= setTemp) |=> isRest);  // R7
  AST_NO_BOTH_ON: assert property (@(posedge clk) disable iff (!rstN)
    !(heaterOn && coolerOn));  // R8
  AST_HEAT_OUT: assert property (@(posedge clk) disable iff (!rstN)
    heaterOn == isHeat);  // R8

endmodule

bind thermo_ctrl thermo_ctrl_chk #(.TEMP_W(TEMP_W), .TOL_W(TOL_W)) u_chk (.*);

// File: tb/thermo_ctrl_bench.sv
module thermo_ctrl_bench;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN;
  logic [7:0] curTemp;
  logic [7:0] setTemp;
  logic [3:0] tolBand;
  logic       heaterOn;
  logic       coolerOn;
  logic [2:0] stateOneHot;

  int nChecks = 0;
  int nFail = 0;
  logic [2:0] modelState;

  always #(CLK_PERIOD/2) clk = ~clk;

  thermo_ctrl u_thermo_ctrl (
    .clk(clk), .rstN(rstN), .curTemp(curTemp), .setTemp(setTemp),
    .tolBand(tolBand), .heaterOn(heaterOn), .coolerOn(coolerOn),
    .stateOneHot(stateOneHot)
  );

  // Reference next state from the requirements (1 rest, 2 heat, 4 cool)
  function automatic logic [2:0] refNext(logic [2:0] s, int c, int d, int t);
    case (s)
      3'b001: return (c + t < d) ? 3'b010 : ((c > d + t) ? 3'b100 : 3'b001);
      3'b010: return (c >= d) ? 3'b001 : 3'b010;
      3'b100: return (c <= d) ? 3'b001 : 3'b100;
      default: return 3'b001;
    endcase
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Checks state and both enables against the model (R2, R8)
  task automatic checkOutputs(string req);
    check(stateOneHot == modelState, req, stateOneHot, modelState);
    check(heaterOn == (modelState == 3'b010) && coolerOn == (modelState == 3'b100),
          "R8", {heaterOn, coolerOn}, {modelState == 3'b010, modelState == 3'b100});
  endtask

  // Apply inputs after a falling edge, clock once, compare at the next falling edge
  task automatic step(int c, int d, int t, string req);
    curTemp = 8'(c);
    setTemp = 8'(d);
    tolBand = 4'(t);
    @(posedge clk);
    modelState = refNext(modelState, c, d, t);
    @(negedge clk);
    checkOutputs(req);
  endtask

  // Closed loop with the slow plant of R10
  task automatic runPlant(int startTemp, int d, int t);
    int temp = startTemp;
    int heatCnt = 0;
    int coolCnt = 0;
    int settled = 0;
    for (int i = 0; i < 4000 && settled < 20; i++) begin
      step(temp, d, t, "R10");
      if (heaterOn) begin
        heatCnt++;
        if (heatCnt == 10) begin temp += 2; heatCnt = 0; end
      end else if (coolerOn) begin
        coolCnt++;
        if (coolCnt == 5) begin temp -= 3; coolCnt = 0; end
      end
      settled = (stateOneHot == 3'b001) ? settled + 1 : 0;
    end
    check(stateOneHot == 3'b001, "R10", stateOneHot, 1);
    check(temp >= d - t && temp <= d + t, "R10", temp, d);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nChecks++;
    nFail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin
    rstN = 1'b0;
    curTemp = 8'd10;
    setTemp = 8'd100;
    tolBand = 4'd3;
    modelState = 3'b001;
    repeat (3) @(negedge clk);
    // R1: reset holds resting despite a cold reading
    check(stateOneHot == 3'b001 && !heaterOn && !coolerOn, "R1",
          {heaterOn, coolerOn, stateOneHot}, 1);
    rstN = 1'b1;

    // Directed: band edges and transitions
    step(97, 100, 3, "R5");   // lower band edge, stays resting
    step(103, 100, 3, "R5");  // upper band edge, stays resting
    step(96, 100, 3, "R3");   // one below lower edge, heating
    step(99, 100, 3, "R6");   // still below the set-point, heating
    step(100, 100, 3, "R6");  // reaches the set-point, resting
    step(104, 100, 3, "R4");  // one above upper edge, cooling
    step(101, 100, 3, "R7");  // still above, cooling
    step(100, 100, 3, "R7");  // reaches the set-point, resting
    step(99, 100, 0, "R3");   // zero tolerance, heating
    step(100, 100, 0, "R6");

    // R9: large tolerance near both ends of the range
    step(0, 0, 15, "R9");
    step(0, 3, 5, "R9");
    step(255, 250, 10, "R9");
    step(255, 255, 15, "R9");
    step(240, 255, 15, "R9");  // 240 + 15 = 255, not below: resting
    step(239, 255, 15, "R9");  // heating
    step(255, 255, 15, "R9");  // back to resting

    // Constrained random readings, mostly clustered near the set-point
    void'($urandom(32'h5EED_1234));
    for (int i = 0; i < 400; i++) begin
      int d = $urandom_range(0, 255);
      int t = $urandom_range(0, 15);
      int c;
      if ($urandom_range(0, 3) == 0) c = $urandom_range(0, 255);
      else begin
        c = d + $urandom_range(0, 40) - 20;
        if (c < 0) c = 0;
        if (c > 255) c = 255;
      end
      step(c, d, t, "R2");
    end

    // R10: closed loop from cold and from hot
    step(100, 100, 4, "R5");
    step(100, 100, 4, "R5");
    runPlant(60, 100, 4);
    runPlant(170, 100, 4);

    // R1: asynchronous reset from an active state
    step(50, 100, 2, "R3");
    rstN = 1'b0;
    #1;
    modelState = 3'b001;
    check(stateOneHot == 3'b001 && !heaterOn, "R1", stateOneHot, 1);
    @(negedge clk);
    rstN = 1'b1;

    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

endmodule